// File: doc/BRIEF.md
# Polar First-Layer LLR Compressor

This block sits at the input of a polar successive-cancellation decoder. Channel log-likelihood ratios arrive one per accepted beat, and a frame holds N of them. The block keeps a channel store that has room for only half the frame. During the first half of a frame it groups the incoming values P at a time and writes each group as one wide word into that store.

During the second half of the frame, each arriving value is operand b and is paired with operand a, the value stored N/2 positions earlier. From each pair the block computes the first-layer check-node result in the same cycle. It also produces a one-bit flag that records which operand supplied the result's magnitude, and a retained operand. The result and the flag go out on an internal-memory write port. The retained operand is written back over the stored entry and is also presented on a channel write-back port. A later stage can rebuild both original operands from the flag, the result and the retained operand.

All write ports are registered, so each one updates one cycle after the beat that causes it. An end-of-frame pulse marks the last pair, and the next accepted beat starts a new frame at index 0.

Top module: `polar_llr_compress`

## Requirements
- R1: While reset is asserted and until the synchronised release completes, every write enable and frame_end are 0 and in_ready is 0. Shortly after release in_ready becomes 1. A reset in the middle of a frame restarts at index 0.
- R2: The first N/2 accepted values of a frame are grouped by index: packet k = index div P, lane j = index mod P. In the cycle after the beat that completes a group, pk_we is 1, pk_addr is k, and bits [j*QC +: QC] of pk_data hold the raw value with index k*P+j.
- R3: During the first half of a frame, im_we and hw_we stay 0. During the second half, pk_we stays 0.
- R4: Accepted beat N/2+i (0 ≤ i < N/2) raises im_we and hw_we in the next cycle, with im_addr = i and hw_addr = i.
- R5: im_f is min(|a|,|b|) after clamping. It is negated when exactly one of a and b is negative.
- R6: im_loc is 0 when |a| ≤ |b|, so equal magnitudes give 0. It is 1 when |a| > |b|.
- R7: hw_data is the clamped b when im_loc is 0 and the clamped a when im_loc is 1. This value replaces stored entry i.
- R8: Values are two's complement QC-bit integers. The code -2^(QC-1) is treated as -(2^(QC-1)-1), so no output carries the most negative code.
- R9: A cycle without an accepted beat (in_valid low) advances nothing and raises no write enable in the next cycle.
- R10: frame_end is 1 for exactly the one cycle after the N-th accepted beat. The following beat is index 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Block accepts a value this cycle |
| in_llr | input | QC | Signed channel value |
| pk_we | output | 1 | Packet write to channel store (first half) |
| pk_addr | output | clog2(N/(2P)) | Packet address |
| pk_data | output | P*QC | Packed raw values, lane j at bits j*QC |
| im_we | output | 1 | Internal-memory write |
| im_addr | output | clog2(N/2) | Internal-memory entry index i |
| im_f | output | QC | First-layer check-node result |
| im_loc | output | 1 | Magnitude-location flag |
| hw_we | output | 1 | Channel write-back of retained operand |
| hw_addr | output | clog2(N/2) | Entry index i being overwritten |
| hw_data | output | QC | Retained operand |
| frame_end | output | 1 | One-cycle pulse after the last pair of a frame |

## Verification
A wrong beat counter appears at the ports in the next cycle. A packet would go to the wrong pk_addr, a pair would be written to the wrong im_addr, or frame_end would come at the wrong beat. A corrupt channel-store entry shows up N/2 beats later, as a wrong im_f or hw_data for that pair. The bench therefore checks every output on every beat of whole frames, including stalls and a reset in the middle of a frame. It uses operands chosen for ties, zeros, sign mixes and the clamped code.

// File: rtl/polar_cmp_pkg.sv
package polar_cmp_pkg;
  typedef enum logic {
    PH_FILL = 1'b0,
    PH_PAIR = 1'b1
  } phase_e;
endpackage

// File: rtl/llr_pair_fn.sv
module llr_pair_fn #(
  parameter int QC = 6
) (
  input  logic [QC-1:0] a_raw,
  input  logic [QC-1:0] b_raw,
  output logic [QC-1:0] f_out,
  output logic          loc_out,
  output logic [QC-1:0] h_out
);
  localparam logic [QC-1:0] MOST_NEG = {1'b1, {(QC-1){1'b0}}};
  localparam logic [QC-1:0] CLAMPED  = {1'b1, {(QC-2){1'b0}}, 1'b1};

  logic [QC-1:0] a_c, b_c, a_mag, b_mag, m_min;

  always_comb begin
    a_c     = (a_raw == MOST_NEG) ? CLAMPED : a_raw;
    b_c     = (b_raw == MOST_NEG) ? CLAMPED : b_raw;
    a_mag   = a_c[QC-1] ? -a_c : a_c;
    b_mag   = b_c[QC-1] ? -b_c : b_c;
    loc_out = (a_mag > b_mag);
    m_min   = loc_out ? b_mag : a_mag;
    f_out   = (a_c[QC-1] ^ b_c[QC-1]) ? -m_min : m_min;
    h_out   = loc_out ? a_c : b_c;
  end

  // R8: clamp keeps the most negative code off both outputs
  always_comb begin
    assert (f_out != MOST_NEG && h_out != MOST_NEG);
  end
endmodule

// File: rtl/llr_chan_store.sv
module llr_chan_store #(
  parameter int QC   = 6,
  parameter int P    = 2,
  parameter int NPKT = 4,
  parameter int AW   = 2,
  parameter int LW   = 1
) (
  input  logic            clk,
  input  logic            fill_we,
  input  logic            fill_last,
  input  logic [AW-1:0]   fill_pkt,
  input  logic [LW-1:0]   fill_lane,
  input  logic [QC-1:0]   fill_llr,
  output logic [P*QC-1:0] pk_word,
  input  logic [AW-1:0]   rd_pkt,
  input  logic [LW-1:0]   rd_lane,
  output logic [QC-1:0]   rd_llr,
  input  logic            wb_we,
  input  logic [QC-1:0]   wb_llr
);
  logic [P*QC-1:0] mem [NPKT];
  logic [P*QC-1:0] stage_q;

  always_comb begin
    pk_word = stage_q;
    pk_word[fill_lane*QC +: QC] = fill_llr;
  end

  assign rd_llr = mem[rd_pkt][rd_lane*QC +: QC];

  always_ff @(posedge clk) begin
    if (fill_we) stage_q <= pk_word;
  end

  always_ff @(posedge clk) begin
    if (fill_we && fill_last) mem[fill_pkt] <= pk_word;
    else if (wb_we)           mem[rd_pkt][rd_lane*QC +: QC] <= wb_llr;
  end

  // R3: the packet write and the write-back never collide
  always_comb begin
    assert (!(fill_we && wb_we));
  end
endmodule

// File: rtl/polar_llr_compress.sv
module polar_llr_compress
  import polar_cmp_pkg::*;
#(
  parameter int N  = 16,
  parameter int P  = 2,
  parameter int QC = 6,
  localparam int HALF = N / 2,
  localparam int NPKT = HALF / P,
  localparam int CW   = $clog2(N),
  localparam int IW   = CW - 1,
  localparam int AW   = (NPKT > 1) ? $clog2(NPKT) : 1,
  localparam int LW   = (P > 1) ? $clog2(P) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [QC-1:0]   in_llr,
  output logic            pk_we,
  output logic [AW-1:0]   pk_addr,
  output logic [P*QC-1:0] pk_data,
  output logic            im_we,
  output logic [IW-1:0]   im_addr,
  output logic [QC-1:0]   im_f,
  output logic            im_loc,
  output logic            hw_we,
  output logic [IW-1:0]   hw_addr,
  output logic [QC-1:0]   hw_data,
  output logic            frame_end
);
  localparam logic [QC-1:0] MOST_NEG = {1'b1, {(QC-1){1'b0}}};

  logic [1:0]      sync_q;
  logic            rst_s_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic            ready_q;
  logic            pk_we_q, pk_we_n, im_we_q, im_we_n, hw_we_q, hw_we_n;
  logic            end_q, end_n;
  logic            accept, last_lane, load_pk, load_pair;
  phase_e          phase;
  logic [IW-1:0]   idx;
  logic [AW-1:0]   pkt;
  logic [LW-1:0]   lane;
  logic [P*QC-1:0] pk_word;
  logic [QC-1:0]   a_llr, f_c, h_c;
  logic            loc_c;
  logic [AW-1:0]   pk_addr_q;
  logic [P*QC-1:0] pk_data_q;
  logic [IW-1:0]   pair_addr_q;
  logic [QC-1:0]   f_q, h_q;
  logic            loc_q;

  // reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_s_n = sync_q[1];

  assign accept    = in_valid && ready_q;
  assign phase     = phase_e'(cnt_q[CW-1]);
  assign idx       = cnt_q[IW-1:0];
  assign pkt       = AW'(idx / IW'(P));
  assign lane      = LW'(idx % IW'(P));
  assign last_lane = (lane == LW'(P - 1));
  assign load_pk   = accept && (phase == PH_FILL) && last_lane;
  assign load_pair = accept && (phase == PH_PAIR);

  llr_chan_store #(.QC(QC), .P(P), .NPKT(NPKT), .AW(AW), .LW(LW)) u_store (
    .clk       (clk),
    .fill_we   (accept && (phase == PH_FILL)),
    .fill_last (last_lane),
    .fill_pkt  (pkt),
    .fill_lane (lane),
    .fill_llr  (in_llr),
    .pk_word   (pk_word),
    .rd_pkt    (pkt),
    .rd_lane   (lane),
    .rd_llr    (a_llr),
    .wb_we     (load_pair),
    .wb_llr    (h_c)
  );

  llr_pair_fn #(.QC(QC)) u_pair (
    .a_raw   (a_llr),
    .b_raw   (in_llr),
    .f_out   (f_c),
    .loc_out (loc_c),
    .h_out   (h_c)
  );

  // next-state
  always_comb begin
    cnt_n   = cnt_q;
    pk_we_n = 1'b0;
    im_we_n = 1'b0;
    hw_we_n = 1'b0;
    end_n   = 1'b0;
    if (accept) begin
      cnt_n = cnt_q + 1'b1;
      if (phase == PH_FILL) begin
        pk_we_n = last_lane;
      end else begin
        im_we_n = 1'b1;
        hw_we_n = 1'b1;
        end_n   = (cnt_q == CW'(N - 1));
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
      pk_we_q <= 1'b0;
      im_we_q <= 1'b0;
      hw_we_q <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      ready_q <= 1'b1;
      pk_we_q <= pk_we_n;
      im_we_q <= im_we_n;
      hw_we_q <= hw_we_n;
      end_q   <= end_n;
    end
  end

  // data registers, clock-enabled
  always_ff @(posedge clk) begin
    if (load_pk) begin
      pk_addr_q <= pkt;
      pk_data_q <= pk_word;
    end
    if (load_pair) begin
      pair_addr_q <= idx;
      f_q         <= f_c;
      loc_q       <= loc_c;
      h_q         <= h_c;
    end
  end

  assign in_ready  = ready_q;
  assign pk_we     = pk_we_q;
  assign pk_addr   = pk_addr_q;
  assign pk_data   = pk_data_q;
  assign im_we     = im_we_q;
  assign im_addr   = pair_addr_q;
  assign im_f      = f_q;
  assign im_loc    = loc_q;
  assign hw_we     = hw_we_q;
  assign hw_addr   = pair_addr_q;
  assign hw_data   = h_q;
  assign frame_end = end_q;

  logic [QC-1:0] f_mag, h_mag;
  assign f_mag = im_f[QC-1] ? -im_f : im_f;
  assign h_mag = hw_data[QC-1] ? -hw_data : hw_data;

  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(pk_we && im_we));

  p_pair_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    im_we |-> hw_we);

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(in_valid && in_ready) |=> (!pk_we && !im_we && !frame_end));

  p_end_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    frame_end |-> (im_we && im_addr == IW'(HALF - 1)));

  p_fmag_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    im_we |-> (f_mag <= h_mag));

  p_loc_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (im_we && im_loc) |-> (f_mag < h_mag));

  p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    im_we |-> (im_f != MOST_NEG && hw_data != MOST_NEG));
endmodule

// File: tb/sim_polar_llr_compress.sv
module sim_polar_llr_compress;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [5:0]  in_llr;
  logic        pk_we;
  logic [1:0]  pk_addr;
  logic [11:0] pk_data;
  logic        im_we;
  logic [2:0]  im_addr;
  logic [5:0]  im_f;
  logic        im_loc;
  logic        hw_we;
  logic [2:0]  hw_addr;
  logic [5:0]  hw_data;
  logic        frame_end;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  polar_llr_compress #(.N(16), .P(2), .QC(6)) u0 (.*);

  // frame 1 inputs; expected pair results for entries 8..15
  localparam int LLR_V [16] = '{5, -7, 12, 0, -20, 31, -32, 9,
                                3, 10, -12, -9, -4, -32, 15, 9};
  localparam int EXP_F [8] = '{3, -7, -12, 0, 4, -31, -15, 9};
  localparam int EXP_L [8] = '{1, 0, 0, 0, 1, 0, 1, 0};
  localparam int EXP_H [8] = '{5, 10, -12, -9, -20, -31, -31, 9};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic beat(input int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_llr   = 6'(v);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle_check();
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R9 pk_we on stall", int'(pk_we), 0);
    chk("R9 im_we on stall", int'(im_we), 0);
    chk("R9 hw_we on stall", int'(hw_we), 0);
    chk("R9 frame_end on stall", int'(frame_end), 0);
  endtask

  function automatic int pack2(input int lo, input int hi);
    return ((hi & 63) << 6) | (lo & 63);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 pk_we in reset", int'(pk_we), 0);
    chk("R1 im_we in reset", int'(im_we), 0);
    chk("R1 hw_we in reset", int'(hw_we), 0);
    chk("R1 frame_end in reset", int'(frame_end), 0);
    chk("R1 in_ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    for (int w = 0; w < 8 && !in_ready; w++) @(negedge clk);
    chk("R1 in_ready after release", int'(in_ready), 1);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_llr = '0;
    do_reset();

    // frame 1 from the table, with stalls in each half
    for (int k = 0; k < 16; k++) begin
      if (k == 3 || k == 11) idle_check();
      beat(LLR_V[k]);
      if (k < 8) begin
        chk("R3 im_we in fill half", int'(im_we), 0);
        chk("R3 hw_we in fill half", int'(hw_we), 0);
        chk("R2 pk_we", int'(pk_we), k % 2);
        if (k % 2 == 1) begin
          chk("R2 pk_addr", int'(pk_addr), k / 2);
          chk("R2 pk_data", int'(pk_data), pack2(LLR_V[k-1], LLR_V[k]));
        end
      end else begin
        chk("R3 pk_we in pair half", int'(pk_we), 0);
        chk("R4 im_we", int'(im_we), 1);
        chk("R4 hw_we", int'(hw_we), 1);
        chk("R4 im_addr", int'(im_addr), k - 8);
        chk("R4 hw_addr", int'(hw_addr), k - 8);
        chk("R5 im_f", int'($signed(im_f)), EXP_F[k-8]);
        chk("R6 im_loc", int'(im_loc), EXP_L[k-8]);
        chk("R7 hw_data", int'($signed(hw_data)), EXP_H[k-8]);
      end
      chk("R10 frame_end", int'(frame_end), (k == 15) ? 1 : 0);
    end
    idle_check();

    // frame 2: clamp corner, every first-half value is the most negative code
    for (int k = 0; k < 16; k++) begin
      int v;
      v = (k < 8) ? -32 : ((k % 2 == 1) ? -32 : 0);
      beat(v);
      if (k == 1) begin
        chk("R10 new frame starts at packet 0", int'(pk_addr), 0);
        chk("R8 raw code kept in packet", int'(pk_data), pack2(-32, -32));
      end
      if (k >= 8) begin
        chk("R4 im_addr frame 2", int'(im_addr), k - 8);
        chk("R8 R5 im_f clamped", int'($signed(im_f)), (k % 2 == 1) ? 31 : 0);
        chk("R6 im_loc frame 2", int'(im_loc), (k % 2 == 1) ? 0 : 1);
        chk("R8 R7 hw_data clamped", int'($signed(hw_data)), -31);
      end
      chk("R10 frame_end frame 2", int'(frame_end), (k == 15) ? 1 : 0);
    end

    // reset in the middle of a frame
    for (int k = 0; k < 5; k++) beat(k + 1);
    do_reset();
    beat(-3);
    chk("R1 no packet after one beat", int'(pk_we), 0);
    beat(7);
    chk("R1 packet after reset", int'(pk_we), 1);
    chk("R1 packet address restarts", int'(pk_addr), 0);
    chk("R2 packet data after reset", int'(pk_data), pack2(-3, 7));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule